// File: doc/BRIEF.md
# HDLC Receive Block Buffer

This block sits between a bit-level HDLC deframer and a host processor. The deframer hands over received bytes one at a time and closes each frame with a status byte. The block stores them in a 64-slot ring that is handled as two 32-byte blocks. It cuts each frame into chunks, and the host works through them one chunk at a time through a single pop port.

A chunk is either a partial block or a message end. A partial block is 32 bytes of a frame that is still arriving. A message end is the tail of a frame: up to 32 data bytes followed by the frame status byte. When a chunk reaches the head of the chunk list, the block raises the matching sticky interrupt bit and shows the chunk's data byte count. The host pops the bytes and then releases the chunk with the command that matches its kind.

The block also detects overflow. A data byte that finds no room is dropped, and the frame it belongs to is marked in its status byte. A new frame that arrives while eight finished frames are still held is discarded as a whole. Either case raises a sticky overflow interrupt. Frames already stored are never touched. The block sizes must be powers of two.

Top module: `hdlc_rx_blockbuf`

## Requirements
- R1: The ring holds 64 slots. Every data byte and every status byte takes one slot. A data byte of an open frame is stored only when at least 2 slots are free; otherwise it is dropped.
- R2: When the open chunk of a frame already holds 32 bytes and the next byte of that frame is stored, those 32 bytes become a partial chunk. When that chunk is at the head, int_raw[0] sets and byte_cnt reads 32.
- R3: in_end on an open frame appends the status byte and closes a message-end chunk. When that chunk is at the head, int_raw[1] sets and byte_cnt gives the number N of data bytes in it (1 to 32), with byte_cnt[7:6] reading zero.
- R4: rd_data shows the next unpopped byte of the head chunk, and pop advances to the byte after it. For a message-end chunk, the N data bytes come out first and the status byte last. Once the chunk is used up, rd_data reads 0x00 and further pops are ignored.
- R5: The status byte is in_stat with bit 7 forced to 1 when any byte of that frame was dropped. A dropped byte sets int_raw[2].
- R6: The first byte of a new frame starts a discarded frame when eight finished frames are held or fewer than 2 slots are free. A discarded frame stores nothing up to its in_end, sets int_raw[2], and creates no chunk.
- R7: rel_blk releases the head chunk only when it is a partial block, and rel_frm releases it only when it is a message end; otherwise each is ignored. A release frees any unpopped bytes of the chunk, and a pop in the same cycle is ignored.
- R8: int_raw bits stay set until the host pulses the matching int_clr bit. When a new set and a clear meet in the same cycle, the set wins.
- R9: irq equals int_raw ANDed with int_en, bit for bit (0 partial block, 1 message end, 2 overflow). The raw bits set whatever the mask is.
- R10: When rst_n is low, all chunks, bytes and frame counts are emptied, and int_raw, byte_cnt and rd_data read zero.
- R11: When in_end and in_vld are high together, the data byte is ignored. An in_end with no open frame is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Deframer data byte strobe |
| in_data | input | 8 | Deframer data byte |
| in_end | input | 1 | End of frame strobe, carries in_stat |
| in_stat | input | 8 | Frame status from the deframer |
| pop | input | 1 | Host pop of the byte on rd_data |
| rd_data | output | 8 | Next byte of the head chunk |
| byte_cnt | output | 8 | Data bytes in the head chunk |
| rel_blk | input | 1 | Host release of a partial-block chunk |
| rel_frm | input | 1 | Host release of a message-end chunk |
| int_clr | input | 3 | Per-bit clear pulse for int_raw |
| int_en | input | 3 | Per-bit interrupt enable |
| int_raw | output | 3 | Sticky raw interrupt bits |
| irq | output | 3 | Masked interrupt outputs |

## Verification
The two functions that can fall in the same cycle are the arrival of a new chunk at the head, which sets a raw interrupt bit, and the host's clear of that same bit. The bench provokes this by holding two short frames, releasing the first, and pulsing the message-end clear on the very next cycle, which is when the second frame is announced. The bit must read set afterwards, and a later clear must then drop it. A long random phase also makes releases, pops, appends and clears collide freely. It is judged cycle by cycle against a queue-based model.

// File: rtl/hdlc_rx_blockbuf.sv
module hdlc_rx_blockbuf #(
  parameter int BLK   = 32,
  parameter int NBLK  = 2,
  parameter int MAXFR = 8,
  parameter int QD    = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_vld,
  input  logic [7:0] in_data,
  input  logic       in_end,
  input  logic [7:0] in_stat,
  input  logic       pop,
  output logic [7:0] rd_data,
  output logic [7:0] byte_cnt,
  input  logic       rel_blk,
  input  logic       rel_frm,
  input  logic [2:0] int_clr,
  input  logic [2:0] int_en,
  output logic [2:0] int_raw,
  output logic [2:0] irq
);
  localparam int CAP = BLK * NBLK;
  localparam int AW  = $clog2(CAP);
  localparam int CW  = $clog2(CAP + 1);
  localparam int LW  = $clog2(BLK + 2);
  localparam int QW  = $clog2(QD);
  localparam int FW  = $clog2(MAXFR + 1);

  logic [7:0]    mem [CAP];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] used;
  logic [LW-1:0] q_len [QD];
  logic          q_end [QD];
  logic [QW-1:0] q_wr, q_rd;
  logic [QW:0]   q_cnt;
  logic [FW-1:0] frames;
  logic [LW-1:0] hd_pop, cur_cnt;
  logic          ann, st_rpf, st_rme, st_ovf;
  logic          fr_open, fr_drop, fr_ovf;

  logic          hd_vld, hd_end, low, byte_ev, start, start_drop, start_ok;
  logic          acc, byte_drop, push_part, fin, push, rel, popg, wr_any, ann_ev;
  logic [LW-1:0] hd_len, hd_rem;
  logic [CW-1:0] free;
  logic [7:0]    wdat;

  assign hd_vld     = q_cnt != '0;
  assign hd_len     = q_len[q_rd];
  assign hd_end     = q_end[q_rd];
  assign hd_rem     = hd_len - hd_pop;
  assign free       = CW'(CAP) - used;
  assign low        = free < CW'(2);
  assign byte_ev    = in_vld & ~in_end;
  assign start      = byte_ev & ~fr_open & ~fr_drop;
  assign start_drop = start & ((frames == FW'(MAXFR)) | low);
  assign start_ok   = start & ~start_drop;
  assign acc        = start_ok | (byte_ev & fr_open & ~low);
  assign byte_drop  = byte_ev & fr_open & low;
  assign push_part  = acc & fr_open & (cur_cnt == LW'(BLK));
  assign fin        = in_end & fr_open;
  assign push       = push_part | fin;
  assign rel        = hd_vld & ((rel_blk & ~hd_end) | (rel_frm & hd_end));
  assign popg       = pop & hd_vld & (hd_rem != '0) & ~rel;
  assign wr_any     = acc | fin;
  assign ann_ev     = hd_vld & ~ann & ~rel;
  assign wdat       = fin ? (in_stat | {fr_ovf, 7'b0}) : in_data;

  assign rd_data  = (hd_vld && hd_rem != '0) ? mem[rd_ptr] : 8'h00;
  assign byte_cnt = !hd_vld ? 8'h00 : hd_end ? 8'(hd_len - LW'(1)) : 8'(hd_len);
  assign int_raw  = {st_ovf, st_rme, st_rpf};
  assign irq      = int_raw & int_en;

  always_ff @(posedge clk) begin
    if (wr_any) mem[wr_ptr] <= wdat;
    if (push) begin
      q_len[q_wr] <= fin ? cur_cnt + LW'(1) : LW'(BLK);
      q_end[q_wr] <= fin;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      used    <= '0;
      q_wr    <= '0;
      q_rd    <= '0;
      q_cnt   <= '0;
      frames  <= '0;
      hd_pop  <= '0;
      cur_cnt <= '0;
      ann     <= 1'b0;
      st_rpf  <= 1'b0;
      st_rme  <= 1'b0;
      st_ovf  <= 1'b0;
      fr_open <= 1'b0;
      fr_drop <= 1'b0;
      fr_ovf  <= 1'b0;
    end else begin
      if (wr_any) wr_ptr <= wr_ptr + AW'(1);
      rd_ptr <= rd_ptr + (rel ? AW'(hd_rem) : AW'(popg));
      used   <= used + CW'(wr_any) - (rel ? CW'(hd_rem) : CW'(popg));
      hd_pop <= rel ? '0 : hd_pop + LW'(popg);
      if (push) q_wr <= q_wr + QW'(1);
      if (rel)  q_rd <= q_rd + QW'(1);
      q_cnt  <= q_cnt + (QW+1)'(push) - (QW+1)'(rel);
      frames <= frames + FW'(fin) - FW'(rel & hd_end);
      ann    <= rel ? 1'b0 : (hd_vld | ann);
      st_rpf <= (st_rpf & ~int_clr[0]) | (ann_ev & ~hd_end);
      st_rme <= (st_rme & ~int_clr[1]) | (ann_ev & hd_end);
      st_ovf <= (st_ovf & ~int_clr[2]) | start_drop | byte_drop;
      if (start_ok) begin
        fr_open <= 1'b1;
        fr_ovf  <= 1'b0;
        cur_cnt <= LW'(1);
      end else if (acc) begin
        cur_cnt <= push_part ? LW'(1) : cur_cnt + LW'(1);
      end
      if (byte_drop) fr_ovf <= 1'b1;
      if (fin) begin
        fr_open <= 1'b0;
        fr_ovf  <= 1'b0;
        cur_cnt <= '0;
      end
      if (start_drop) fr_drop <= 1'b1;
      else if (in_end && fr_drop) fr_drop <= 1'b0;
    end
  end

  AST_USED_CAP:    assert property (@(posedge clk) disable iff (!rst_n) used <= CW'(CAP)); // R1
  AST_RPF_HOLD:    assert property (@(posedge clk) disable iff (!rst_n) st_rpf && !int_clr[0] |=> st_rpf); // R8
  AST_RME_HOLD:    assert property (@(posedge clk) disable iff (!rst_n) st_rme && !int_clr[1] |=> st_rme); // R8
  AST_DROP_FLAG:   assert property (@(posedge clk) disable iff (!rst_n) byte_drop |=> st_ovf); // R5
  AST_FRAME_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) frames <= FW'(MAXFR)); // R6
  AST_POP_BOUND:   assert property (@(posedge clk) disable iff (!rst_n) hd_vld |-> hd_pop <= hd_len); // R4
  AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (!rst_n) q_cnt <= (QW+1)'(QD)); // R2
endmodule

// File: tb/tb_hdlc_rx_blockbuf.sv
module tb_hdlc_rx_blockbuf;
  logic       clk = 0, rst_n = 0;
  logic       in_vld = 0, in_end = 0, pop = 0, rel_blk = 0, rel_frm = 0;
  logic [7:0] in_data = 0, in_stat = 0;
  logic [2:0] int_clr = 0, int_en = 3'b111;
  logic [7:0] rd_data, byte_cnt;
  logic [2:0] int_raw, irq;
  int total = 0, bad = 0;
  bit cmp_on = 0;

  always #5 clk = ~clk;

  hdlc_rx_blockbuf dut (.clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data(in_data),
    .in_end(in_end), .in_stat(in_stat), .pop(pop), .rd_data(rd_data), .byte_cnt(byte_cnt),
    .rel_blk(rel_blk), .rel_frm(rel_frm), .int_clr(int_clr), .int_en(int_en),
    .int_raw(int_raw), .irq(irq));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  byte unsigned dq[$];
  int cl[$];
  bit ce[$];
  int m_hp, m_frames, m_ccnt, t_free, t_hl, t_rem;
  bit m_ann, m_r0, m_r1, m_r2, m_open, m_drop, m_fovf;
  bit t_hv, t_he, t_bev, t_st, t_sd, t_acc, t_bd, t_pp, t_fin, t_rl, t_pg, t_ae;

  always @(posedge clk) begin
    if (!rst_n) begin
      dq.delete(); cl.delete(); ce.delete();
      m_hp = 0; m_frames = 0; m_ccnt = 0;
      {m_ann, m_r0, m_r1, m_r2, m_open, m_drop, m_fovf} = '0;
    end else begin
      t_free = 64 - dq.size();
      t_hv = cl.size() > 0;
      t_hl = t_hv ? cl[0] : 0;
      t_he = t_hv ? ce[0] : 0;
      t_rem = t_hl - m_hp;
      t_bev = in_vld && !in_end;
      t_st = t_bev && !m_open && !m_drop;
      t_sd = t_st && (m_frames == 8 || t_free < 2);
      t_acc = t_bev && ((t_st && !t_sd) || (m_open && t_free >= 2));
      t_bd = t_bev && m_open && t_free < 2;
      t_pp = t_acc && m_open && m_ccnt == 32;
      t_fin = in_end && m_open;
      t_rl = t_hv && ((rel_blk && !t_he) || (rel_frm && t_he));
      t_pg = pop && t_hv && t_rem > 0 && !t_rl;
      t_ae = t_hv && !m_ann && !t_rl;
      m_r0 = (m_r0 && !int_clr[0]) || (t_ae && !t_he);
      m_r1 = (m_r1 && !int_clr[1]) || (t_ae && t_he);
      m_r2 = (m_r2 && !int_clr[2]) || t_sd || t_bd;
      m_ann = t_rl ? 0 : (t_hv || m_ann);
      if (t_rl) begin
        repeat (t_rem) void'(dq.pop_front());
        void'(cl.pop_front()); void'(ce.pop_front());
        if (t_he) m_frames--;
        m_hp = 0;
      end else if (t_pg) begin
        void'(dq.pop_front());
        m_hp++;
      end
      if (t_acc) dq.push_back(in_data);
      if (t_fin) dq.push_back(in_stat | (m_fovf ? 8'h80 : 8'h00));
      if (t_pp) begin cl.push_back(32); ce.push_back(0); end
      if (t_fin) begin cl.push_back(m_ccnt + 1); ce.push_back(1); m_frames++; end
      if (t_st && !t_sd) begin m_open = 1; m_fovf = 0; m_ccnt = 1; end
      else if (t_acc) m_ccnt = t_pp ? 1 : m_ccnt + 1;
      if (t_bd) m_fovf = 1;
      if (t_fin) begin m_open = 0; m_fovf = 0; m_ccnt = 0; end
      if (t_sd) m_drop = 1;
      else if (in_end && m_drop) m_drop = 0;
    end
  end

  always @(posedge clk) begin
    #2;
    if (rst_n && cmp_on) begin
      chk("R4 model rd_data", rd_data, (cl.size() > 0 && cl[0] - m_hp > 0) ? dq[0] : 8'h00);
      chk("R3 model byte_cnt", byte_cnt,
          cl.size() == 0 ? 8'h00 : ce[0] ? 8'(cl[0] - 1) : 8'(cl[0]));
      chk("R8 model int_raw", {5'b0, int_raw}, {5'b0, m_r2, m_r1, m_r0});
      chk("R9 model irq", {5'b0, irq}, {5'b0, {m_r2, m_r1, m_r0} & int_en});
    end
  end

  // stimulus tasks, each entered and left at a falling edge
  task automatic put_byte(input logic [7:0] d);
    in_vld = 1; in_data = d; @(negedge clk); in_vld = 0;
  endtask
  task automatic put_end(input logic [7:0] s);
    in_end = 1; in_stat = s; @(negedge clk); in_end = 0;
  endtask
  task automatic do_pop();
    pop = 1; @(negedge clk); pop = 0;
  endtask
  task automatic rel_b();
    rel_blk = 1; @(negedge clk); rel_blk = 0;
  endtask
  task automatic rel_f();
    rel_frm = 1; @(negedge clk); rel_frm = 0;
  endtask
  task automatic clr(input logic [2:0] m);
    int_clr = m; @(negedge clk); int_clr = 0;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R10 act=running exp=finished");
    summary();
  end

  initial begin
    idle(3);
    rst_n = 1;
    cmp_on = 1;
    idle(1);
    chk("R10 reset int_raw", {5'b0, int_raw}, 8'h00);
    chk("R10 reset byte_cnt", byte_cnt, 8'h00);
    chk("R10 reset rd_data", rd_data, 8'h00);

    // short frame
    for (int i = 0; i < 5; i++) put_byte(8'h10 + 8'(i));
    put_end(8'h05);
    idle(2);
    chk("R3 short frame rme", {7'b0, int_raw[1]}, 8'h01);
    chk("R3 short frame count", byte_cnt, 8'h05);
    chk("R9 irq rme", {7'b0, irq[1]}, 8'h01);
    for (int i = 0; i < 5; i++) begin
      chk("R4 short data", rd_data, 8'h10 + 8'(i));
      do_pop();
    end
    chk("R4 status byte", rd_data, 8'h05);
    do_pop();
    chk("R4 exhausted reads zero", rd_data, 8'h00);
    do_pop();
    chk("R4 extra pop ignored count", byte_cnt, 8'h05);
    clr(3'b010);
    rel_f();
    idle(2);
    chk("R7 released empty", byte_cnt, 8'h00);
    chk("R8 cleared", {5'b0, int_raw}, 8'h00);

    // long frame with overflow
    for (int i = 0; i < 70; i++) put_byte(8'(i));
    put_end(8'h3C);
    idle(2);
    chk("R2 partial count", byte_cnt, 8'd32);
    chk("R5 R1 raw bits", {5'b0, int_raw}, 8'h05);
    for (int i = 0; i < 32; i++) begin
      chk("R2 partial data", rd_data, 8'(i));
      do_pop();
    end
    chk("R4 partial used up", rd_data, 8'h00);
    rel_f();
    idle(1);
    chk("R7 wrong release ignored", byte_cnt, 8'd32);
    chk("R7 wrong release no rme", {7'b0, int_raw[1]}, 8'h00);
    clr(3'b101);
    rel_b();
    idle(2);
    chk("R3 tail rme", {5'b0, int_raw}, 8'h02);
    chk("R1 tail count", byte_cnt, 8'd31);
    for (int i = 32; i < 63; i++) begin
      chk("R1 tail data", rd_data, 8'(i));
      do_pop();
    end
    chk("R5 status overflow bit", rd_data, 8'hBC);
    do_pop();
    clr(3'b010);
    rel_f();
    idle(2);

    // frame limit
    for (int k = 0; k < 8; k++) begin
      put_byte(8'hA0 + 8'(k));
      put_end(8'(k));
    end
    put_byte(8'hEE);
    put_byte(8'hEF);
    put_end(8'h77);
    idle(1);
    chk("R6 ninth frame overflow", {7'b0, int_raw[2]}, 8'h01);
    clr(3'b100);
    for (int k = 0; k < 8; k++) begin
      idle(2);
      chk("R6 kept frame count", byte_cnt, 8'h01);
      chk("R6 kept frame data", rd_data, 8'hA0 + 8'(k));
      do_pop();
      chk("R6 kept frame status", rd_data, 8'(k));
      clr(3'b010);
      rel_f();
    end
    idle(2);
    chk("R6 ninth frame absent", byte_cnt, 8'h00);
    chk("R6 no further raw", {5'b0, int_raw}, 8'h00);

    // set and clear in the same cycle
    put_byte(8'h31); put_end(8'h01);
    put_byte(8'h32); put_end(8'h02);
    idle(2);
    rel_f();
    clr(3'b010);
    chk("R8 set wins over clear", {7'b0, int_raw[1]}, 8'h01);
    chk("R8 second frame head", rd_data, 8'h32);
    clr(3'b010);
    chk("R8 later clear", {7'b0, int_raw[1]}, 8'h00);
    rel_f();
    idle(2);

    // mask
    put_byte(8'h44); put_end(8'h00);
    int_en = 3'b000;
    idle(2);
    chk("R9 masked irq", {5'b0, irq}, 8'h00);
    chk("R9 raw while masked", {5'b0, int_raw}, 8'h02);
    int_en = 3'b010;
    idle(1);
    chk("R9 unmasked irq", {5'b0, irq}, 8'h02);
    int_en = 3'b111;
    clr(3'b010);
    rel_f();
    idle(2);

    // end strobe corner cases
    in_vld = 1; in_data = 8'h99; in_end = 1; in_stat = 8'h11;
    idle(1);
    in_vld = 0; in_end = 0;
    idle(2);
    chk("R11 stray end ignored", byte_cnt, 8'h00);
    chk("R11 stray end no raw", {5'b0, int_raw}, 8'h00);
    put_byte(8'h55);
    in_vld = 1; in_data = 8'h66; in_end = 1; in_stat = 8'h01;
    idle(1);
    in_vld = 0; in_end = 0;
    idle(2);
    chk("R11 byte with end dropped", byte_cnt, 8'h01);
    chk("R11 kept byte", rd_data, 8'h55);
    clr(3'b010);
    rel_f();
    idle(2);

    // random traffic against the model
    for (int c = 0; c < 6000; c++) begin
      in_vld  = $urandom_range(0, 99) < 45;
      in_data = 8'($urandom);
      in_end  = $urandom_range(0, 99) < 4;
      in_stat = 8'($urandom);
      pop     = $urandom_range(0, 99) < 50;
      rel_blk = $urandom_range(0, 99) < 5;
      rel_frm = $urandom_range(0, 99) < 5;
      int_clr = ($urandom_range(0, 99) < 10) ? 3'($urandom) : 3'b000;
      if ($urandom_range(0, 99) < 3) int_en = 3'($urandom);
      @(negedge clk);
    end
    {in_vld, in_end, pop, rel_blk, rel_frm} = '0;
    int_clr = 0;
    idle(2);

    rst_n = 0;
    idle(2);
    rst_n = 1;
    idle(1);
    chk("R10 mid-run reset raw", {5'b0, int_raw}, 8'h00);
    chk("R10 mid-run reset count", byte_cnt, 8'h00);
    chk("R10 mid-run reset data", rd_data, 8'h00);
    idle(2);
    summary();
  end
endmodule